// File: doc/BRIEF.md
# Millisecond-Window Input Debounce Filter

This block settles noisy GPIO input lines before the rest of the controller uses them. Each line has its own filter. A filter holds its filtered level until the input has kept a different value for a whole settle window. The window is a power of two in milliseconds, from 1 ms to 128 ms. Each line's control word selects the window length and turns the filter on or off. When a line's filter is off, the raw input goes straight to the output in the same cycle.

A shared prescaler divides the system clock into a one-cycle strobe once per millisecond. Every filter counts these strobes while its input disagrees with its filtered level. A filter restarts its count when the input comes back to the filtered level, or when software changes the line's window or enable. The inputs must already be synchronized to `clk`. Pulses shorter than one clock are not filtered.

Top module: `pin_settle_filter`

## Requirements
- R1: `ms_tick` is high for exactly one cycle in every `CLKS_PER_MS` cycles. It first goes high in the cycle after the `CLKS_PER_MS`-th rising edge that samples `rst` low.
- R2: In each line's 9-bit control word, bit 8 is the filter enable and bits 7:5 are the rate code r. Bits 4:0 have no effect on any output.
- R3: With the filter enabled, the filtered level takes the new input value in the cycle after the clock edge that samples the 2^r-th `ms_tick` counted while the input differs. It changes at no other time, so the settle delay lies between 2^r-1 and 2^r milliseconds.
- R4: If the input returns to the filtered level before the window ends, the count is discarded. A later change needs a full new window.
- R5: With the enable bit clear, `pin_out` equals `pin_in` for that line in the same cycle.
- R6: Any change of a line's enable bit or rate code restarts that line's count from zero. In the cycle after the change, the line's output does not move.
- R7: While `rst` is high, each line's filtered level is loaded with its current input and its count is cleared. After reset, each enabled output equals the input sampled at the last reset edge.
- R8: Each line's filter depends only on its own input and control word. Activity on one line never changes another line's output.
- R9: Rate code 0 gives a window of one tick. Rate code 7 gives a window of 128 ticks.
- R10: While a filter is disabled, its filtered level tracks the input. When the filter is enabled again, it starts from the input level and produces no spurious transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PINS | Synchronized raw input lines |
| ctrl_word | input | NUM_PINS*9 | Per-line control words; line i occupies bits i*9+8 down to i*9 |
| pin_out | output | NUM_PINS | Debounced (or bypassed) levels |
| ms_tick | output | 1 | One-cycle millisecond strobe from the prescaler |

## Verification
The bench builds the block with four lines and `CLKS_PER_MS` = 4, so one millisecond is four cycles. At that setting the longest window of 128 ticks takes 512 cycles, and directed runs can reach the 1-tick and 128-tick extremes. Window restarts, bounce rejection and disable/re-enable can then all be exercised in a few hundred cycles each. Four lines are enough for a seeded random phase to run different rates and bounce patterns side by side, which shows that the lines stay independent.

// File: rtl/pin_settle_pkg.sv
package pin_settle_pkg;

    // Control word layout: bit positions the filter decodes.
    localparam int EN_BIT   = 8;
    localparam int RATE_LSB = 5;
    localparam int RATE_W   = 3;
    localparam int CTRL_W   = EN_BIT + 1;

    // Largest code selects 2^MAX_RATE ticks; counter must hold that value.
    localparam int MAX_RATE = (1 << RATE_W) - 1;
    localparam int CNT_W    = MAX_RATE + 1;

    typedef struct packed {
        logic              en;
        logic [RATE_W-1:0] rate;
    } settle_cfg_t;

    typedef enum logic [1:0] {
        ACT_BYPASS  = 2'd0,  // filter off: follow input
        ACT_RESTART = 2'd1,  // configuration just changed
        ACT_MATCH   = 2'd2,  // input agrees with filtered level
        ACT_PENDING = 2'd3   // input disagrees, accumulate ticks
    } settle_act_t;

    function automatic settle_cfg_t decode_ctrl(input logic [CTRL_W-1:0] word);
        settle_cfg_t c;
        c.en   = word[EN_BIT];
        c.rate = word[RATE_LSB +: RATE_W];
        return c;
    endfunction

    function automatic logic [CNT_W-1:0] window_ticks(input logic [RATE_W-1:0] r);
        return CNT_W'(1) << r;
    endfunction

endpackage

// File: rtl/settle_tick_gen.sv
module settle_tick_gen #(
    parameter int CLKS_PER_MS = 50000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int DIV_W = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLKS_PER_MS - 1);

    logic tick_q;

    generate
        if (CLKS_PER_MS > 1) begin : g_div
            logic [DIV_W-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    div_q  <= '0;
                    tick_q <= 1'b0;
                end else if (div_q == DIV_LAST) begin
                    div_q  <= '0;
                    tick_q <= 1'b1;
                end else begin
                    div_q  <= div_q + DIV_W'(1);
                    tick_q <= 1'b0;
                end
            end
        end else begin : g_every
            always_ff @(posedge clk) begin
                if (rst) tick_q <= 1'b0;
                else     tick_q <= 1'b1;
            end
        end
    endgenerate

    assign tick_o = tick_q;
endmodule

// File: rtl/settle_lane.sv
module settle_lane
    import pin_settle_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pin_i,
    input  settle_cfg_t cfg_i,
    input  logic        tick_i,
    output logic        level_o
);
    settle_cfg_t      cfg_q;
    logic             filt_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             expire;
    settle_act_t      act;

    always_comb begin
        if (!cfg_i.en)            act = ACT_BYPASS;
        else if (cfg_i != cfg_q)  act = ACT_RESTART;
        else if (pin_i == filt_q) act = ACT_MATCH;
        else                      act = ACT_PENDING;
    end

    assign cnt_inc = cnt_q + CNT_W'(1);
    assign expire  = tick_i && (cnt_inc == window_ticks(cfg_i.rate));

    always_ff @(posedge clk) begin
        if (rst) begin
            filt_q <= pin_i;
            cnt_q  <= '0;
            cfg_q  <= cfg_i;
        end else begin
            cfg_q <= cfg_i;
            unique case (act)
                ACT_BYPASS: begin
                    filt_q <= pin_i;
                    cnt_q  <= '0;
                end
                ACT_RESTART, ACT_MATCH: begin
                    cnt_q <= '0;
                end
                ACT_PENDING: begin
                    if (expire) begin
                        filt_q <= pin_i;
                        cnt_q  <= '0;
                    end else if (tick_i) begin
                        cnt_q <= cnt_inc;
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    assign level_o = cfg_i.en ? filt_q : pin_i;
endmodule

// File: rtl/pin_settle_filter.sv
module pin_settle_filter
    import pin_settle_pkg::*;
#(
    parameter int NUM_PINS    = 4,
    parameter int CLKS_PER_MS = 50000
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_PINS-1:0]        pin_in,
    input  logic [NUM_PINS*CTRL_W-1:0] ctrl_word,
    output logic [NUM_PINS-1:0]        pin_out,
    output logic                       ms_tick
);
    logic tick;

    settle_tick_gen #(
        .CLKS_PER_MS(CLKS_PER_MS)
    ) tick_i (
        .clk   (clk),
        .rst   (rst),
        .tick_o(tick)
    );

    assign ms_tick = tick;

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_lane
            settle_cfg_t cfg;
            assign cfg = decode_ctrl(ctrl_word[i*CTRL_W +: CTRL_W]);

            settle_lane lane_i (
                .clk    (clk),
                .rst    (rst),
                .pin_i  (pin_in[i]),
                .cfg_i  (cfg),
                .tick_i (tick),
                .level_o(pin_out[i])
            );
        end
    endgenerate
endmodule

// File: rtl/pin_settle_filter_chk.sv
module pin_settle_filter_chk
    import pin_settle_pkg::*;
#(
    parameter int NUM_PINS    = 4,
    parameter int CLKS_PER_MS = 50000
) (
    input logic                       clk,
    input logic                       rst,
    input logic [NUM_PINS-1:0]        pin_in,
    input logic [NUM_PINS*CTRL_W-1:0] ctrl_word,
    input logic [NUM_PINS-1:0]        pin_out,
    input logic                       ms_tick
);
    generate
        if (CLKS_PER_MS > 1) begin : g_tick
            // R1
            tick_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
                ms_tick |=> !ms_tick);
        end

        for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
            logic              en_w;
            logic [RATE_W-1:0] rate_w;
            assign en_w   = ctrl_word[i*CTRL_W + EN_BIT];
            assign rate_w = ctrl_word[i*CTRL_W + RATE_LSB +: RATE_W];

            // R5
            bypass_follow_chk: assert property (@(posedge clk) disable iff (rst)
                !en_w |-> (pin_out[i] == pin_in[i]));

            // R3
            move_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
                (en_w && $past(en_w) && !$past(rst) && (pin_out[i] != $past(pin_out[i])))
                |-> $past(ms_tick));

            // R4
            agree_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (en_w && (pin_in[i] == pin_out[i]))
                |=> (!en_w || (pin_out[i] == $past(pin_out[i]))));

            // R6
            cfg_restart_chk: assert property (@(posedge clk) disable iff (rst)
                (en_w && ({en_w, rate_w} != $past({en_w, rate_w})))
                |=> (!en_w || (pin_out[i] == $past(pin_out[i]))));

            // R7
            reset_load_chk: assert property (@(posedge clk) disable iff (rst)
                $fell(rst) |-> (!en_w || (pin_out[i] == $past(pin_in[i]))));
        end
    endgenerate
endmodule

bind pin_settle_filter pin_settle_filter_chk #(
    .NUM_PINS   (NUM_PINS),
    .CLKS_PER_MS(CLKS_PER_MS)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .pin_in   (pin_in),
    .ctrl_word(ctrl_word),
    .pin_out  (pin_out),
    .ms_tick  (ms_tick)
);

// File: tb/pin_settle_filter_tb_top.sv
module pin_settle_filter_tb_top;
    localparam int NP = 4;
    localparam int P  = 4;
    localparam int CW = 9;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NP-1:0]    pin_r = '0;
    logic [NP*CW-1:0] ctrl_r = '0;
    logic [NP-1:0]    pin_out;
    logic             ms_tick;

    always #10 clk = ~clk;

    pin_settle_filter #(.NUM_PINS(NP), .CLKS_PER_MS(P)) dut_i (
        .clk(clk), .rst(rst), .pin_in(pin_r), .ctrl_word(ctrl_r),
        .pin_out(pin_out), .ms_tick(ms_tick)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    string cur_req = "R7";

    // Reference state, derived from the requirements.
    int m_pre;
    bit m_tick;
    bit m_filt [NP];
    int m_cnt  [NP];
    bit m_en_q [NP];
    int m_rate_q [NP];

    function automatic bit f_en(int i);
        return ctrl_r[i*CW + 8];
    endfunction
    function automatic int f_rate(int i);
        return int'(ctrl_r[i*CW + 5 +: 3]);
    endfunction

    task automatic check(bit ok, string req, int act, int exp, string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_pre  = 0;
            m_tick = 0;
            for (int i = 0; i < NP; i++) begin
                m_filt[i]   = pin_r[i];
                m_cnt[i]    = 0;
                m_en_q[i]   = f_en(i);
                m_rate_q[i] = f_rate(i);
            end
        end else begin
            for (int i = 0; i < NP; i++) begin
                if (!f_en(i)) begin
                    m_filt[i] = pin_r[i];
                    m_cnt[i]  = 0;
                end else if (f_en(i) != m_en_q[i] || f_rate(i) != m_rate_q[i]) begin
                    m_cnt[i] = 0;
                end else if (pin_r[i] == m_filt[i]) begin
                    m_cnt[i] = 0;
                end else if (m_tick) begin
                    if (m_cnt[i] + 1 == (1 << f_rate(i))) begin
                        m_filt[i] = pin_r[i];
                        m_cnt[i]  = 0;
                    end else begin
                        m_cnt[i]++;
                    end
                end
                m_en_q[i]   = f_en(i);
                m_rate_q[i] = f_rate(i);
            end
            if (m_pre == P - 1) begin
                m_pre  = 0;
                m_tick = 1;
            end else begin
                m_pre++;
                m_tick = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(ms_tick == m_tick, "R1", ms_tick, m_tick, "ms_tick");
            for (int i = 0; i < NP; i++) begin
                bit exp_v;
                exp_v = f_en(i) ? m_filt[i] : pin_r[i];
                check(pin_out[i] == exp_v, f_en(i) ? cur_req : "R5",
                      pin_out[i], exp_v, $sformatf("pin_out[%0d]", i));
            end
        end
    end

    function automatic logic [CW-1:0] mk_ctrl(bit en, int rate, int junk);
        return {en, 3'(rate), 5'(junk)};
    endfunction

    task automatic set_ctrl(int i, bit en, int rate, int junk);
        ctrl_r[i*CW +: CW] = mk_ctrl(en, rate, junk);
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired t=%0t", $time);
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        // R7: reset loads the current input level.
        pin_r = 4'b1010;
        for (int i = 0; i < NP; i++) set_ctrl(i, 1, 1, 0);
        wait_cyc(3);
        rst = 0;
        wait_cyc(1);
        check(pin_out == 4'b1010, "R7", pin_out, 4'b1010, "pin_out after reset");
        wait_cyc(6);

        // R9: shortest and longest windows.
        cur_req = "R9";
        set_ctrl(0, 1, 0, 0);
        set_ctrl(1, 1, 7, 0);
        wait_cyc(2);
        pin_r[0] = 1'b1;
        pin_r[1] = 1'b0;
        wait_cyc(2 * P + 2);
        check(pin_out[0] == 1'b1, "R9", pin_out[0], 1, "rate 0 settled");
        wait_cyc(100 * P);
        check(pin_out[1] == 1'b1, "R9", pin_out[1], 1, "rate 7 still holding");
        wait_cyc(30 * P);
        check(pin_out[1] == 1'b0, "R9", pin_out[1], 0, "rate 7 settled");

        // R4: bouncing input on a 4-tick window.
        cur_req = "R4";
        set_ctrl(2, 1, 2, 0);
        wait_cyc(2);
        for (int k = 0; k < 5; k++) begin
            pin_r[2] = 1'b1;
            wait_cyc(9);
            pin_r[2] = 1'b0;
            wait_cyc(3);
        end
        check(pin_out[2] == 1'b0, "R4", pin_out[2], 0, "bounce rejected");
        pin_r[2] = 1'b1;
        wait_cyc(5 * P + 2);
        check(pin_out[2] == 1'b1, "R4", pin_out[2], 1, "steady change accepted");

        // R6: rate change mid-window restarts the count.
        cur_req = "R6";
        set_ctrl(3, 1, 2, 0);
        wait_cyc(2);
        pin_r[3] = ~pin_r[3];
        wait_cyc(3 * P);
        set_ctrl(3, 1, 3, 0);
        wait_cyc(5 * P);
        check(pin_out[3] != pin_r[3], "R6", pin_out[3], !pin_r[3], "restarted window");
        wait_cyc(5 * P);
        check(pin_out[3] == pin_r[3], "R6", pin_out[3], pin_r[3], "settled after restart");

        // R5: bypass with the filter off.
        cur_req = "R5";
        set_ctrl(0, 0, 5, 0);
        for (int k = 0; k < 40; k++) begin
            pin_r[0] = 1'($urandom_range(0, 1));
            wait_cyc(1);
        end

        // R10: re-enable starts from the current level.
        cur_req = "R10";
        pin_r[0] = ~pin_out[0];
        wait_cyc(2);
        set_ctrl(0, 1, 1, 0);
        wait_cyc(1);
        check(pin_out[0] == pin_r[0], "R10", pin_out[0], pin_r[0], "no edge on re-enable");
        wait_cyc(6 * P);

        // R2: low control bits carry junk.
        cur_req = "R2";
        for (int k = 0; k < 20; k++) begin
            for (int i = 0; i < NP; i++) set_ctrl(i, 1, i, int'($urandom_range(0, 31)));
            if ((k % 4) == 0) pin_r = 4'($urandom_range(0, 15));
            wait_cyc(1);
        end
        // Junk bits change only: the rate is unchanged so no restart occurs.
        wait_cyc(20 * P);

        // R8 and R3: independent random activity per line.
        for (int ph = 0; ph < 2; ph++) begin
            cur_req = (ph == 0) ? "R8" : "R3";
            for (int c = 0; c < 3000; c++) begin
                if ((c % 300) == 0)
                    for (int i = 0; i < NP; i++)
                        set_ctrl(i, ($urandom_range(0, 7) != 0), int'($urandom_range(0, 3)),
                                 int'($urandom_range(0, 31)));
                for (int i = 0; i < NP; i++)
                    if ($urandom_range(0, 39) == 0) pin_r[i] = ~pin_r[i];
                wait_cyc(1);
            end
        end

        finish_run();
    end
endmodule